// File: doc/BRIEF.md
# Three-Wire Control Receiver

This block takes configuration writes from a slow three-wire serial port: a serial data line, a serial clock and a latch line. All three lines are brought into the system clock domain through flop synchronizers, and their edges are found there. Each rising edge of the serial clock shifts one data bit into a 16-bit shift register, most significant bit first.

A rising edge on the latch line commits the word, but only if at least 16 bits have arrived since the previous latch edge. The upper 7 bits are the register address and the lower 9 bits are the data value. The block then issues a one-cycle write strobe with that address and data. It also stores the value in a small on-block register file, whose contents are always visible on a flat output bus.

A select input enables the receiver only when it selects three-wire operation. The other setting stands for a two-wire port that is not built here, so with that setting the receiver stays idle. Each level on the serial lines must be held for at least two system clock cycles.

Top module: `ctl3w_rx`

## Requirements
- R1: The data line is sampled at each rising edge of the serial clock. Changes on the data line while the serial clock is high or low between rising edges have no effect on the received bit.
- R2: A word is 16 bits long. The first bit received ends up as bit 15 and the last bit received ends up as bit 0.
- R3: On a commit, `wr_addr_o` carries word bits 15..9 and `wr_data_o` carries word bits 8..0.
- R4: A commit happens only on a rising edge of `latch_i`. Each such edge yields at most one `wr_o` pulse, exactly one system clock cycle wide. Holding the latch line high or lowering it produces no strobe.
- R5: With `wire3_sel_i` = 0 (two-wire selected), serial clock and latch edges produce no strobe and leave `cfg_o` unchanged. With `wire3_sel_i` = 1 the receiver is active.
- R6: If more than 16 bits arrive before the latch edge, the last 16 bits received form the word.
- R7: If fewer than 16 bits arrive before the latch edge, the word is dropped: no strobe is issued and `cfg_o` is unchanged.
- R8: The bit count restarts at zero after every latch rising edge. Bits received before a latch edge never count toward the next word.
- R9: A committed write to address a < NUM_REGS stores the 9-bit data value in `cfg_o[a*9 +: 9]`. A write to a higher address still strobes but changes no stored value.
- R10: After reset, `wr_o` is 0 and every stored register in `cfg_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wire3_sel_i | input | 1 | 1 selects the three-wire receiver; 0 leaves it idle |
| latch_i | input | 1 | Serial latch line; its rising edge commits the word |
| sclk_i | input | 1 | Serial bit clock |
| sdata_i | input | 1 | Serial data, most significant bit first |
| wr_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 7 | Register address of the committed write |
| wr_data_o | output | 9 | Data value of the committed write |
| cfg_o | output | NUM_REGS*9 | Stored register values; register r sits at bits r*9 +: 9 |

## Verification
The bench goes after word length at both edges. With 15 bits, a receiver that commits on the latch edge regardless of count would write a stale or shifted word. With 20 bits, one that stops at 16 would keep the leading junk bits instead of the trailing word. It sends a full word followed by a short burst, which catches a bit counter that is not cleared at the latch edge, because such a counter would let the short burst commit. It also flips the data line while the serial clock is high, so a receiver sampling on the wrong edge or on level picks up inverted bits. Further cases cover writes above the register file, which must strobe without storing, and the two-wire setting, where any strobe or change in stored state marks a missing enable gate.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned DATA_W = 9;
  localparam int unsigned WORD_W = ADDR_W + DATA_W;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } ctl_word_t;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  generate
    if (STAGES < 2) begin : g_bad_stages
      initial $error("ctl3w_sync: STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift
  import ctl3w_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      latch_i,
  input  logic      sclk_i,
  input  logic      sdata_i,
  output logic      commit_o,
  output ctl_word_t word_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic              latch_q, sclk_q;
  logic              latch_rise, sclk_rise;
  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;

  assign latch_rise = latch_i & ~latch_q;
  assign sclk_rise  = sclk_i & ~sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q  <= 1'b0;
      sclk_q   <= 1'b0;
      shreg_q  <= '0;
      cnt_q    <= '0;
      commit_o <= 1'b0;
      word_o   <= '0;
    end else begin
      latch_q  <= latch_i;
      sclk_q   <= sclk_i;
      commit_o <= 1'b0;
      if (latch_rise) begin
        // latch edge wins over a coincident bit edge; count always restarts
        cnt_q <= '0;
        if (en_i && cnt_q == CNT_FULL) begin
          commit_o <= 1'b1;
          word_o   <= ctl_word_t'(shreg_q);
        end
      end else if (en_i && sclk_rise) begin
        shreg_q <= {shreg_q[WORD_W-2:0], sdata_i};
        if (cnt_q != CNT_FULL) cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL); // R6
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_rise |=> cnt_q == '0); // R8
endmodule

// File: rtl/ctl3w_regs.sv
module ctl3w_regs
  import ctl3w_pkg::*;
#(
  parameter int unsigned NUM_REGS = 24
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          data_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_REGS; r++) regs_q[r] <= '0;
    end else if (we_i) begin
      for (int r = 0; r < NUM_REGS; r++)
        if (addr_i == ADDR_W'(r)) regs_q[r] <= data_i;
    end
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
      assign regs_o[g*DATA_W +: DATA_W] = regs_q[g];
    end
  endgenerate

  AST_NO_STORE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i >= ADDR_W'(NUM_REGS)) |=> $stable(regs_o)); // R9
endmodule

// File: rtl/ctl3w_rx.sv
module ctl3w_rx
  import ctl3w_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wire3_sel_i,
  input  logic                       latch_i,
  input  logic                       sclk_i,
  input  logic                       sdata_i,
  output logic                       wr_o,
  output logic [ADDR_W-1:0]          wr_addr_o,
  output logic [DATA_W-1:0]          wr_data_o,
  output logic [NUM_REGS*DATA_W-1:0] cfg_o
);
  logic      sel_s, latch_s, sclk_s, sdata_s;
  logic      commit;
  ctl_word_t word;

  ctl3w_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({wire3_sel_i, latch_i, sclk_i, sdata_i}),
    .q_o    ({sel_s, latch_s, sclk_s, sdata_s})
  );

  ctl3w_shift u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (sel_s),
    .latch_i  (latch_s),
    .sclk_i   (sclk_s),
    .sdata_i  (sdata_s),
    .commit_o (commit),
    .word_o   (word)
  );

  ctl3w_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (commit),
    .addr_i (word.addr),
    .data_i (word.data),
    .regs_o (cfg_o)
  );

  assign wr_o      = commit;
  assign wr_addr_o = word.addr;
  assign wr_data_o = word.data;

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o); // R4
  AST_MODE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(sel_s)); // R5
  AST_CFG_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_o) |-> $stable(cfg_o)); // R7
endmodule

// File: tb/ctl3w_rx_tb_top.sv
module ctl3w_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 24;
  localparam int HB         = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b1, latch = 1'b0, sclk = 1'b0, sdata = 1'b0;
  logic wr;
  logic [6:0] wr_addr;
  logic [8:0] wr_data;
  logic [NREG*9-1:0] cfg;

  int checks = 0, fails = 0, strobes = 0;
  logic [6:0] last_addr = '0;
  logic [8:0] last_data = '0;
  logic [8:0] exp_cfg [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl3w_rx #(.NUM_REGS(NREG), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wire3_sel_i(sel), .latch_i(latch),
    .sclk_i(sclk), .sdata_i(sdata), .wr_o(wr), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .cfg_o(cfg)
  );

  always @(posedge clk) if (wr) begin
    strobes++;
    last_addr = wr_addr;
    last_data = wr_data;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // glitch=1 flips data while the serial clock is high
  task automatic send_bits(input logic [31:0] bits, input int n, input bit glitch);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sdata = bits[i];
      wait_cyc(HB); sclk = 1'b1;
      wait_cyc(HB/2); if (glitch) sdata = ~bits[i];
      wait_cyc(HB/2); sclk = 1'b0;
    end
  endtask

  task automatic pulse_latch();
    @(negedge clk); latch = 1'b1;
    wait_cyc(4*HB); latch = 1'b0;
    wait_cyc(4*HB);
  endtask

  task automatic check_cfg(input string req);
    for (int r = 0; r < NREG; r++)
      chk(cfg[r*9 +: 9] == exp_cfg[r], req, cfg[r*9 +: 9], exp_cfg[r]);
  endtask

  // full write: expects strobe and optional store
  task automatic write_word(input logic [6:0] a, input logic [8:0] d, input bit glitch, input string req);
    int s0 = strobes;
    send_bits({16'h0, a, d}, 16, glitch);
    pulse_latch();
    chk(strobes - s0 == 1, req, strobes - s0, 1);
    chk(last_addr == a, req, last_addr, a);
    chk(last_data == d, req, last_data, d);
    if (a < NREG) exp_cfg[a] = d;
    check_cfg(req);
  endtask

  task automatic t_reset();
    chk(wr == 1'b0, "R10", wr, 0);
    for (int r = 0; r < NREG; r++) exp_cfg[r] = '0;
    check_cfg("R10");
  endtask

  task automatic t_basic();
    write_word(7'd5, 9'h1A3, 1'b0, "R2_R3");
    write_word(7'd0, 9'h1FF, 1'b0, "R3");
    write_word(7'(NREG-1), 9'h001, 1'b0, "R9");
    write_word(7'd9, 9'h0AA, 1'b0, "R2");
  endtask

  task automatic t_high_addr();
    write_word(7'h7F, 9'h155, 1'b0, "R9");
    write_word(7'(NREG), 9'h0F0, 1'b0, "R9");
  endtask

  task automatic t_edge_sample();
    write_word(7'h2C - 7'h20, 9'h136, 1'b1, "R1");
  endtask

  task automatic t_long();
    int s0 = strobes;
    send_bits({12'h0, 4'b1011, 7'd17, 9'h0C3}, 20, 1'b0);
    pulse_latch();
    chk(strobes - s0 == 1, "R6", strobes - s0, 1);
    chk(last_addr == 7'd17, "R6", last_addr, 17);
    chk(last_data == 9'h0C3, "R6", last_data, 9'h0C3);
    exp_cfg[17] = 9'h0C3;
    check_cfg("R6");
  endtask

  task automatic t_short();
    int s0 = strobes;
    send_bits({17'h0, 7'd3, 8'hFF}, 15, 1'b0);
    pulse_latch();
    chk(strobes == s0, "R7", strobes - s0, 0);
    check_cfg("R7");
  endtask

  task automatic t_restart();
    int s0;
    write_word(7'd4, 9'h077, 1'b0, "R8");
    s0 = strobes;
    send_bits(32'h0000_00C5, 8, 1'b0);
    pulse_latch();
    chk(strobes == s0, "R8", strobes - s0, 0);
    pulse_latch();
    chk(strobes == s0, "R4", strobes - s0, 0);
    check_cfg("R8");
  endtask

  task automatic t_latch_level();
    int s0;
    send_bits({16'h0, 7'd6, 9'h101}, 16, 1'b0);
    s0 = strobes;
    @(negedge clk); latch = 1'b1;
    wait_cyc(40);
    chk(strobes - s0 == 1, "R4", strobes - s0, 1);
    latch = 1'b0;
    wait_cyc(20);
    chk(strobes - s0 == 1, "R4", strobes - s0, 1);
    exp_cfg[6] = 9'h101;
    check_cfg("R4");
  endtask

  task automatic t_mode();
    int s0 = strobes;
    @(negedge clk); sel = 1'b0;
    wait_cyc(8);
    send_bits({16'h0, 7'd2, 9'h1EE}, 16, 1'b0);
    pulse_latch();
    chk(strobes == s0, "R5", strobes - s0, 0);
    check_cfg("R5");
    sel = 1'b1;
    wait_cyc(8);
    write_word(7'd2, 9'h1EE, 1'b0, "R5");
  endtask

  initial begin
    wait_cyc(5);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset();
    t_basic();
    t_high_addr();
    t_edge_sample();
    t_long();
    t_short();
    t_restart();
    t_latch_level();
    t_mode();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule